// File: doc/BRIEF.md
# Dual-Port Synchronous Static RAM with Selectable Read Latency

This block is a true dual-port synchronous memory with two independent ports, named left and right. Each port has its own clock, its own reset and its own set of controls: an active-low primary enable, an active-high secondary enable, a read/write select, an active-low output enable that acts without a clock, an address, and a data word. The bidirectional data pins are modelled as separate data-in and data-out buses plus a drive-enable flag. A pad ring combines these into a tri-state buffer.

A per-port mode input chooses the read latency:

- **Flow-through mode:** the word read at a clock edge is presented right after that edge.
- **Pipelined mode:** the read data passes through a second register stage. The registered port-select follows the same two-stage path, so a port needs two edges to stop driving after it is deselected.

Either port can write a word that the other port later reads.

The address width defaults to 10 bits, which keeps the default elaboration small. Set `ADDR_W` to 15 for the full 32K-word by 9-bit array.

Top module: `dual_port_sync_ram`

## Requirements
- R1: A port is selected at a rising edge only when its primary enable (active low) is 0 and its secondary enable is 1. A deselected edge writes nothing. In flow-through mode, the port stops driving right after that edge.
- R2: A selected edge with read/write = 0 (0 = write, 1 = read) stores the data-in word at the address. That edge does not make the port drive its outputs.
- R3: In flow-through mode (mode = 0), take a selected edge with read/write = 1 while output enable is 0. From that edge until the next edge, the port drives (drive-enable = 1) the word stored at that address.
- R4: While the output enable (active low) is 1, the drive-enable is 0 whatever the clock does. Lowering the output enable between edges restores the drive at once.
- R5: In pipelined mode (mode = 1), read data and drive-enable appear one edge later than in flow-through mode.
- R6: In pipelined mode, the port keeps driving for one more cycle after the first deselected edge. It stops after the second deselected edge.
- R7: Either port reads a word written by the other port. Accesses by both ports in the same cycle to different addresses both complete.
- R8: After reset, both ports have drive-enable 0 until a read is made.
- R9: While a port's drive-enable is 0, its data-out bus is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkL | input | 1 | Left port clock |
| rstNL | input | 1 | Left port asynchronous reset, active low |
| ce0NL | input | 1 | Left primary enable, active low |
| ce1L | input | 1 | Left secondary enable, active high |
| rwL | input | 1 | Left read/write select, 1 = read |
| oeNL | input | 1 | Left output enable, active low, unclocked |
| modeL | input | 1 | Left latency mode, 1 = pipelined |
| addrL | input | ADDR_W | Left address |
| dinL | input | DATA_W | Left write data |
| doutL | output | DATA_W | Left read data |
| doeL | output | 1 | Left data drive-enable |
| clkR | input | 1 | Right port clock |
| rstNR | input | 1 | Right port asynchronous reset, active low |
| ce0NR | input | 1 | Right primary enable, active low |
| ce1R | input | 1 | Right secondary enable, active high |
| rwR | input | 1 | Right read/write select, 1 = read |
| oeNR | input | 1 | Right output enable, active low, unclocked |
| modeR | input | 1 | Right latency mode, 1 = pipelined |
| addrR | input | ADDR_W | Right address |
| dinR | input | DATA_W | Right write data |
| doutR | output | DATA_W | Right read data |
| doeR | output | 1 | Right data drive-enable |

## Verification
A write on one port and a read on the other can fall on the same clock edge.

The bench provokes this in two ways:
- Both ports write distinct addresses on one edge, then each reads the other's word on a shared edge.
- One port writes while the other reads an unrelated address on the same edge.

Each read is judged against a model held in the bench. Same-address collisions with a write are never scored, because either the old or the new word is acceptable there.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Per-port strobes from the control to the datapath
  typedef struct packed {
    logic wrEn;     // store data-in at this edge
    logic rdLoad;   // capture the addressed word at this edge
    logic pipeSel;  // present the second read stage
    logic drive;    // data bus driven now
  } portStrobes_t;

endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
  import dpr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ce0N,
  input  logic         ce1,
  input  logic         rwSel,
  input  logic         oeN,
  input  logic         pipeMode,
  output portStrobes_t strb
);

  logic portSel;
  logic selStage1;
  logic selStage2;
  logic window;

  assign portSel = !ce0N && ce1;

  // Registered read select; the second stage serves the pipelined mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selStage1 <= 1'b0;
      selStage2 <= 1'b0;
    end else begin
      selStage1 <= portSel && rwSel;
      selStage2 <= selStage1;
    end
  end

  assign window = pipeMode ? selStage2 : selStage1;

  always_comb begin
    strb.wrEn    = portSel && !rwSel;
    strb.rdLoad  = portSel && rwSel;
    strb.pipeSel = pipeMode;
    strb.drive   = window && !oeN;   // output enable bypasses the clock
  end

endmodule

// File: rtl/dpr_datapath.sv
module dpr_datapath
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic [1:0]             clk,
  input  logic [1:0]             rstN,
  input  portStrobes_t [1:0]     strb,
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0][DATA_W-1:0] din,
  output logic [1:0][DATA_W-1:0] dout
);

  localparam int DEPTH = 1 << ADDR_W;

  // Two banks, one per writing port; a word is the XOR of both banks
  logic [DATA_W-1:0] bankL [DEPTH];
  logic [DATA_W-1:0] bankR [DEPTH];

  always_ff @(posedge clk[0]) begin
    if (strb[0].wrEn) bankL[addr[0]] <= din[0] ^ bankR[addr[0]];
  end

  always_ff @(posedge clk[1]) begin
    if (strb[1].wrEn) bankR[addr[1]] <= din[1] ^ bankL[addr[1]];
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [DATA_W-1:0] memWord;
    logic [DATA_W-1:0] rdStage1;
    logic [DATA_W-1:0] rdStage2;

    assign memWord = bankL[addr[p]] ^ bankR[addr[p]];

    always_ff @(posedge clk[p] or negedge rstN[p]) begin
      if (!rstN[p]) begin
        rdStage1 <= '0;
        rdStage2 <= '0;
      end else begin
        if (strb[p].rdLoad) rdStage1 <= memWord;
        rdStage2 <= rdStage1;
      end
    end

    assign dout[p] = strb[p].drive ? (strb[p].pipeSel ? rdStage2 : rdStage1) : '0;
  end

endmodule

// File: rtl/dual_port_sync_ram.sv
module dual_port_sync_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clkL,
  input  logic              rstNL,
  input  logic              ce0NL,
  input  logic              ce1L,
  input  logic              rwL,
  input  logic              oeNL,
  input  logic              modeL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] dinL,
  output logic [DATA_W-1:0] doutL,
  output logic              doeL,
  input  logic              clkR,
  input  logic              rstNR,
  input  logic              ce0NR,
  input  logic              ce1R,
  input  logic              rwR,
  input  logic              oeNR,
  input  logic              modeR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] dinR,
  output logic [DATA_W-1:0] doutR,
  output logic              doeR
);

  logic [1:0]             clkV, rstV, ce0NV, ce1V, rwV, oeNV, modeV;
  logic [1:0][ADDR_W-1:0] addrV;
  logic [1:0][DATA_W-1:0] dinV, doutV;
  portStrobes_t [1:0]     strbV;

  assign clkV  = {clkR, clkL};
  assign rstV  = {rstNR, rstNL};
  assign ce0NV = {ce0NR, ce0NL};
  assign ce1V  = {ce1R, ce1L};
  assign rwV   = {rwR, rwL};
  assign oeNV  = {oeNR, oeNL};
  assign modeV = {modeR, modeL};
  assign addrV = {addrR, addrL};
  assign dinV  = {dinR, dinL};

  for (genvar p = 0; p < 2; p++) begin : g_ctrl
    dpr_port_ctrl u_ctrl (
      .clk      (clkV[p]),
      .rstN     (rstV[p]),
      .ce0N     (ce0NV[p]),
      .ce1      (ce1V[p]),
      .rwSel    (rwV[p]),
      .oeN      (oeNV[p]),
      .pipeMode (modeV[p]),
      .strb     (strbV[p])
    );
  end

  dpr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk  (clkV),
    .rstN (rstV),
    .strb (strbV),
    .addr (addrV),
    .din  (dinV),
    .dout (doutV)
  );

  assign doutL = doutV[0];
  assign doutR = doutV[1];
  assign doeL  = strbV[0].drive;
  assign doeR  = strbV[1].drive;

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int DATA_W = 9
) (
  input logic              clkL,
  input logic              rstNL,
  input logic              ce0NL,
  input logic              ce1L,
  input logic              rwL,
  input logic              oeNL,
  input logic              modeL,
  input logic [DATA_W-1:0] doutL,
  input logic              doeL,
  input logic              clkR,
  input logic              rstNR,
  input logic              oeNR,
  input logic [DATA_W-1:0] doutR,
  input logic              doeR
);

  logic       selL;
  logic [1:0] armCnt;

  assign selL = !ce0NL && ce1L;

  // Counts edges since reset so that look-back checks start only on real history
  always_ff @(posedge clkL or negedge rstNL) begin
    if (!rstNL)              armCnt <= '0;
    else if (armCnt != 2'd3) armCnt <= armCnt + 2'd1;
  end

  p_desel_hiz_r1: assert property (@(posedge clkL) disable iff (!rstNL)
    (!modeL && $past(!modeL) && $past(!selL)) |-> !doeL);

  p_write_quiet_r2: assert property (@(posedge clkL) disable iff (!rstNL)
    (!modeL && $past(!modeL) && $past(selL && !rwL)) |-> !doeL);

  p_flow_drive_r3: assert property (@(posedge clkL) disable iff (!rstNL)
    (armCnt >= 2'd2 && !modeL && $past(!modeL) && $past(selL && rwL) && !oeNL) |-> doeL);

  p_oe_block_r4: assert property (@(posedge clkL) disable iff (!rstNL)
    oeNL |-> !doeL);

  p_oe_block_right_r4: assert property (@(posedge clkR) disable iff (!rstNR)
    oeNR |-> !doeR);

  p_pipe_drive_r5: assert property (@(posedge clkL) disable iff (!rstNL)
    (armCnt == 2'd3 && modeL && $past(modeL) && $past(modeL, 2) &&
     $past(selL && rwL, 2) && !oeNL) |-> doeL);

  p_pipe_desel_r6: assert property (@(posedge clkL) disable iff (!rstNL)
    (modeL && $past(modeL) && $past(modeL, 2) && $past(!selL) && $past(!selL, 2)) |-> !doeL);

  p_quiet_zero_r9: assert property (@(posedge clkL) disable iff (!rstNL)
    !doeL |-> (doutL == '0));

  p_quiet_zero_right_r9: assert property (@(posedge clkR) disable iff (!rstNR)
    !doeR |-> (doutR == '0));

endmodule

bind dual_port_sync_ram dpr_checker #(.DATA_W(DATA_W)) u_chk (
  .clkL  (clkL),
  .rstNL (rstNL),
  .ce0NL (ce0NL),
  .ce1L  (ce1L),
  .rwL   (rwL),
  .oeNL  (oeNL),
  .modeL (modeL),
  .doutL (doutL),
  .doeL  (doeL),
  .clkR  (clkR),
  .rstNR (rstNR),
  .oeNR  (oeNR),
  .doutR (doutR),
  .doeR  (doeR)
);

// File: tb/tb_dual_port_sync_ram.sv
`timescale 1ns/1ps
module tb_dual_port_sync_ram;

  localparam int AW = 10;
  localparam int DW = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic clkL, clkR;
  assign clkL = clk;
  assign clkR = clk;

  logic rstN;
  logic ce0NL, ce1L, rwL, oeNL, modeL;
  logic ce0NR, ce1R, rwR, oeNR, modeR;
  logic [AW-1:0] addrL, addrR;
  logic [DW-1:0] dinL, dinR, doutL, doutR;
  logic doeL, doeR;

  dual_port_sync_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clkL(clkL), .rstNL(rstN), .ce0NL(ce0NL), .ce1L(ce1L), .rwL(rwL), .oeNL(oeNL),
    .modeL(modeL), .addrL(addrL), .dinL(dinL), .doutL(doutL), .doeL(doeL),
    .clkR(clkR), .rstNR(rstN), .ce0NR(ce0NR), .ce1R(ce1R), .rwR(rwR), .oeNR(oeNR),
    .modeR(modeR), .addrR(addrR), .dinR(dinR), .doutR(doutR), .doeR(doeR)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [DW-1:0] refMem [1 << AW];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drvL(input logic c0n, input logic c1, input logic rw,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0NL = c0n; ce1L = c1; rwL = rw; addrL = a; dinL = d;
    if (!c0n && c1 && !rw) refMem[a] = d;
  endtask

  task automatic drvR(input logic c0n, input logic c1, input logic rw,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0NR = c0n; ce1R = c1; rwR = rw; addrR = a; dinR = d;
    if (!c0n && c1 && !rw) refMem[a] = d;
  endtask

  task automatic idleBoth();
    drvL(1'b1, 1'b0, 1'b1, '0, '0);
    drvR(1'b1, 1'b0, 1'b1, '0, '0);
  endtask

  // R8: reset leaves both ports quiet
  task automatic tReset();
    rstN = 1'b0;
    idleBoth();
    oeNL = 1'b0; oeNR = 1'b0; modeL = 1'b0; modeR = 1'b0;
    repeat (3) @(negedge clk);
    chk(doeL == 1'b0, "R8 left drive after reset", doeL, 0);
    chk(doeR == 1'b0, "R8 right drive after reset", doeR, 0);
    chk(doutL == '0, "R9 left data while quiet", doutL, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(doeL == 1'b0 && doeR == 1'b0, "R8 quiet after release", {doeL, doeR}, 0);
  endtask

  // R2, R3: flow-through writes and reads on the left port
  task automatic tFlowWriteRead();
    logic [AW-1:0] aList [4] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA};
    logic [DW-1:0] dList [4] = '{9'h1A5, 9'h05A, 9'h1FF, 9'h100};
    modeL = 1'b0; oeNL = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); drvL(1'b0, 1'b1, 1'b0, aList[i], dList[i]);
      @(negedge clk);
      chk(doeL == 1'b0, "R2 write edge does not drive", doeL, 0);
    end
    for (int i = 0; i < 4; i++) begin
      drvL(1'b0, 1'b1, 1'b1, aList[i], '0);
      @(negedge clk);
      chk(doeL == 1'b1 && doutL == refMem[aList[i]], "R3 flow read data",
          doutL, refMem[aList[i]]);
    end
    drvL(1'b0, 1'b0, 1'b1, '0, '0);
    @(negedge clk);
    chk(doeL == 1'b0, "R1 flow deselect stops drive next edge", doeL, 0);
  endtask

  // R1: writes with an enable combination other than (0,1) are ignored
  task automatic tDeselWriteIgnored();
    logic [AW-1:0] a = 10'h0F0;
    modeL = 1'b0; oeNL = 1'b0;
    @(negedge clk); drvL(1'b0, 1'b1, 1'b0, a, 9'h033);
    @(negedge clk); ce0NL = 1'b1; ce1L = 1'b1; rwL = 1'b0; dinL = 9'h1CC;
    @(negedge clk);
    chk(doeL == 1'b0, "R1 primary enable high keeps quiet", doeL, 0);
    ce0NL = 1'b0; ce1L = 1'b0; dinL = 9'h0EE;
    @(negedge clk);
    chk(doeL == 1'b0, "R1 secondary enable low keeps quiet", doeL, 0);
    ce0NL = 1'b1; ce1L = 1'b0; dinL = 9'h111;
    @(negedge clk);
    drvL(1'b0, 1'b1, 1'b1, a, '0);
    @(negedge clk);
    chk(doutL == 9'h033 && doeL, "R1 deselected writes left word intact", doutL, 9'h033);
    // read attempted while deselected gives no drive
    ce0NL = 1'b1;
    @(negedge clk);
    chk(doeL == 1'b0, "R1 deselected read gives no drive", doeL, 0);
  endtask

  // R4: output enable acts between edges
  task automatic tOutputEnable();
    logic [AW-1:0] a = 10'h155;
    modeL = 1'b0; oeNL = 1'b0;
    @(negedge clk); drvL(1'b0, 1'b1, 1'b1, a, '0);
    @(negedge clk);
    chk(doeL == 1'b1, "R4 driving before output enable rises", doeL, 1);
    #0.5 oeNL = 1'b1;
    #0.5 chk(doeL == 1'b0 && doutL == '0, "R4 drive drops mid-cycle", doeL, 0);
    #0.5 oeNL = 1'b0;
    #0.5 chk(doeL == 1'b1 && doutL == refMem[a], "R4 drive returns mid-cycle", doutL, refMem[a]);
    @(negedge clk); oeNL = 1'b1;
    @(negedge clk);
    chk(doeL == 1'b0, "R4 read edge with enable high stays quiet", doeL, 0);
    oeNL = 1'b0;
    #0.5 chk(doeL == 1'b1 && doutL == refMem[a], "R4 late enable reveals read word", doutL, refMem[a]);
    drvL(1'b1, 1'b0, 1'b1, '0, '0);
  endtask

  // R5, R6: pipelined latency and two-edge deselect on the right port
  task automatic tPipelined();
    logic [AW-1:0] a0 = 10'h021;
    logic [AW-1:0] a1 = 10'h3C3;
    modeR = 1'b1; oeNR = 1'b0;
    @(negedge clk); drvR(1'b0, 1'b1, 1'b0, a0, 9'h0C3);
    @(negedge clk); drvR(1'b0, 1'b1, 1'b0, a1, 9'h13C);
    @(negedge clk); drvR(1'b0, 1'b1, 1'b1, a0, '0);
    @(negedge clk);
    chk(doeR == 1'b0, "R5 no drive one edge after pipelined read", doeR, 0);
    drvR(1'b0, 1'b1, 1'b1, a1, '0);
    @(negedge clk);
    chk(doeR == 1'b1 && doutR == 9'h0C3, "R5 pipelined data after two edges", doutR, 9'h0C3);
    drvR(1'b0, 1'b0, 1'b1, '0, '0);
    @(negedge clk);
    chk(doeR == 1'b1 && doutR == 9'h13C, "R6 still driving after first deselect edge", doutR, 9'h13C);
    @(negedge clk);
    chk(doeR == 1'b0, "R6 quiet after second deselect edge", doeR, 0);
    modeR = 1'b0;
  endtask

  // R7: both ports active on the same edges, distinct addresses
  task automatic tCrossPort();
    logic [AW-1:0] aL = 10'h0AA;
    logic [AW-1:0] aR = 10'h255;
    modeL = 1'b0; modeR = 1'b0; oeNL = 1'b0; oeNR = 1'b0;
    @(negedge clk);
    drvL(1'b0, 1'b1, 1'b0, aL, 9'h0F1);
    drvR(1'b0, 1'b1, 1'b0, aR, 9'h18E);
    @(negedge clk);
    drvL(1'b0, 1'b1, 1'b1, aR, '0);
    drvR(1'b0, 1'b1, 1'b1, aL, '0);
    @(negedge clk);
    chk(doeL && doutL == 9'h18E, "R7 left reads right's word", doutL, 9'h18E);
    chk(doeR && doutR == 9'h0F1, "R7 right reads left's word", doutR, 9'h0F1);
    // write on one port while the other reads elsewhere
    drvL(1'b0, 1'b1, 1'b0, 10'h111, 9'h077);
    drvR(1'b0, 1'b1, 1'b1, aR, '0);
    @(negedge clk);
    chk(doeR && doutR == 9'h18E, "R7 right read beside left write", doutR, 9'h18E);
    idleBoth();
    drvR(1'b0, 1'b1, 1'b1, 10'h111, '0);
    @(negedge clk);
    chk(doeR && doutR == 9'h077, "R7 right sees left's new word", doutR, 9'h077);
    idleBoth();
  endtask

  bit done = 1'b0;

  initial begin
    tReset();
    tFlowWriteRead();
    tDeselWriteIgnored();
    tOutputEnable();
    tPipelined();
    tCrossPort();
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule